// File: doc/BRIEF.md
# Countdown Timer with Periodic Reload and Watchdog Variant

This block is a 32-bit countdown timer seen by software as one bus register. A write that carries a nonzero count starts the counter at that value at once, and the counter drops by one on every system clock with no prescaler. A write whose count field is zero halts it. The top bit of the written word asks for automatic reload: the timer keeps a copy of the count and restarts from it each time it expires. This turns the timer into a periodic tick source.

A parameter picks one of two builds. The interrupt build pulses an interrupt line for one clock each time the count reaches zero. The watchdog build has no reload and no interrupt. When it expires it pulses a reset request for one clock, then sits at zero until software writes it again. Software keeps a watchdog from firing by writing a fresh count before the old one runs out.

Top module: `cdtimer`

## Requirements
- R1: After reset the read word is 0 and both the interrupt and the reset request are low.
- R2: A write with a nonzero count field (bits 30:0) loads that count, and the count then falls by exactly one per clock. A read returns the reload flag in bit 31 and the current count in bits 30:0.
- R3: A write while the counter is running replaces the count at once, and counting continues from the new value.
- R4: A write whose bits 30:0 are zero stops the counter at 0 and clears the reload flag, whatever bit 31 holds. The counter stays at 0 and gives no pulse.
- R5: In the interrupt build, the interrupt is high for exactly one clock, N clocks after the write of count N without reload, on the clock where the count reaches 0.
- R6: In the interrupt build, a write with bit 31 set gives one interrupt every N clocks, starting N clocks after the write, and the count reads back as N right after each expiry. A write of 0x80013880 gives its first interrupt 80000 clocks after the write.
- R7: A write that lands on the clock where the count would expire takes priority. No pulse is produced, and the new count is loaded.
- R8: In the watchdog build, bit 31 is ignored and reads as 0, and the interrupt stays low. Expiry gives a one-clock reset request, after which the count stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write word: bit 31 reload request, bits 30:0 count |
| rd_data | output | 32 | Read word: bit 31 reload flag, bits 30:0 current count |
| irq | output | 1 | One-clock expiry pulse (interrupt build) |
| rst_req | output | 1 | One-clock expiry pulse (watchdog build) |

## Verification
The hardest case to reach is a write that arrives on exactly the clock where the count passes from one to zero. The stimulus gets there by loading a small count and then waiting one clock fewer than that count before writing again. The bench then confirms that the pulse is suppressed and the new value has loaded. The periodic mode is covered by counting pulses over several periods, so that a pulse that is off by one clock or missing breaks the pattern. The long 80000-clock period is also run through to its first pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic {
    VAR_IRQ  = 1'b0,
    VAR_WDOG = 1'b1
  } tmr_variant_e;

endpackage

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int           DATA_W  = 32,
  parameter tmr_variant_e VARIANT = VAR_IRQ
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-2:0] cnt_o,
  output logic              auto_o,
  output logic              expire_o
);

  localparam int CW = DATA_W - 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          auto_q, auto_d;
  logic [CW-1:0] rl_val;
  logic          load_nz;
  logic          auto_req;
  logic          expire;
  logic          cnt_en;

  assign load_nz  = (wr_data[CW-1:0] != '0);
  assign auto_req = wr_data[DATA_W-1] & (VARIANT == VAR_IRQ);
  assign expire   = !wr_en && (cnt_q == CW'(1));
  assign cnt_en   = wr_en || (cnt_q != '0);

  // Reload storage exists only where reload is supported
  generate
    if (VARIANT == VAR_IRQ) begin : g_reload
      logic [CW-1:0] rl_q;
      logic          rl_en;
      assign rl_en = wr_en && load_nz;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rl_q <= '0;
        else if (rl_en) rl_q <= wr_data[CW-1:0];
      end
      assign rl_val = rl_q;
    end else begin : g_noreload
      assign rl_val = '0;
    end
  endgenerate

  always_comb begin
    cnt_d  = cnt_q;
    auto_d = auto_q;
    if (wr_en) begin
      cnt_d  = wr_data[CW-1:0];
      auto_d = load_nz && auto_req;
    end else if (expire) begin
      cnt_d  = auto_q ? rl_val : '0;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      auto_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      auto_q <= auto_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign auto_o   = auto_q;
  assign expire_o = expire;

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && cnt_q > CW'(1)) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R3
  load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt_q == $past(wr_data[CW-1:0])));

  // R4
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CW-1:0] == '0) |=> (cnt_q == '0 && !auto_q));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && auto_q) |=> (cnt_q == $past(rl_val) && auto_q));

endmodule

// File: rtl/tmr_expiry.sv
module tmr_expiry
  import tmr_pkg::*;
#(
  parameter tmr_variant_e VARIANT = VAR_IRQ
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic expire,
  output logic irq_o,
  output logic rst_req_o
);

  logic pulse_q, pulse_d;

  assign pulse_d = expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  generate
    if (VARIANT == VAR_IRQ) begin : g_irq
      assign irq_o     = pulse_q;
      assign rst_req_o = 1'b0;
    end else begin : g_wdog
      assign irq_o     = 1'b0;
      assign rst_req_o = pulse_q;
    end
  endgenerate

  // R7
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !(irq_o || rst_req_o));

endmodule

// File: rtl/cdtimer.sv
module cdtimer
  import tmr_pkg::*;
#(
  parameter int           DATA_W  = 32,
  parameter tmr_variant_e VARIANT = VAR_IRQ
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              rst_req
);

  localparam int CW = DATA_W - 1;

  logic [CW-1:0] cnt;
  logic          auto_rl;
  logic          expire;

  tmr_count #(.DATA_W(DATA_W), .VARIANT(VARIANT)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cnt_o    (cnt),
    .auto_o   (auto_rl),
    .expire_o (expire)
  );

  tmr_expiry #(.VARIANT(VARIANT)) u_expiry (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .expire    (expire),
    .irq_o     (irq),
    .rst_req_o (rst_req)
  );

  assign rd_data = {auto_rl, cnt};

  // R5
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_data[DATA_W-1]) |=> !irq);

  // R8
  wdog_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (!rst_req && (rd_data == '0 || $past(wr_en))));

endmodule

// File: tb/test_cdtimer.sv
module test_cdtimer;
  import tmr_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {write word, clocks to wait, expected read, expected irq}
  localparam logic [80:0] VEC [NVEC] = '{
    {32'd10,         16'd3, 32'd7,          1'b0},  // R2
    {32'd5,          16'd5, 32'd0,          1'b1},  // R5
    {32'h8000_0004,  16'd4, 32'h8000_0004,  1'b1},  // R6
    {32'h0001_2345,  16'd0, 32'h0001_2345,  1'b0},  // R2
    {32'h8000_0000,  16'd2, 32'd0,          1'b0},  // R4
    {32'h7FFF_FFFF,  16'd1, 32'h7FFF_FFFE,  1'b0},  // R2
    {32'd0,          16'd3, 32'd0,          1'b0}   // R4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_en_wd = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, rd_data_wd;
  logic        irq, rst_req, irq_wd, rst_req_wd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdtimer #(.DATA_W(32), .VARIANT(VAR_IRQ)) i_cdtimer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .rst_req(rst_req));

  cdtimer #(.DATA_W(32), .VARIANT(VAR_WDOG)) i_cdtimer_wd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_wd), .wr_data(wr_data),
    .rd_data(rd_data_wd), .irq(irq_wd), .rst_req(rst_req_wd));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic wr(input logic wd, input logic [31:0] v);
    wr_data = v;
    if (wd) wr_en_wd = 1'b1; else wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    wr_en_wd = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pulses;
    tick(2);
    // R1 reset state
    chk("R1 rd", rd_data, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 wd rst_req", {31'd0, rst_req_wd}, 32'd0);
    rst_n = 1'b1;
    tick(1);

    for (int i = 0; i < NVEC; i++) begin
      wr(1'b0, VEC[i][80:49]);
      tick(int'(VEC[i][48:33]));
      chk($sformatf("vec%0d rd (R2/R4/R5/R6)", i), rd_data, VEC[i][32:1]);
      chk($sformatf("vec%0d irq (R5/R6)", i), {31'd0, irq}, {31'd0, VEC[i][0]});
    end

    // R5 single pulse then stays stopped
    wr(1'b0, 32'd3);
    tick(2);
    chk("R5 no early pulse", {31'd0, irq}, 32'd0);
    tick(1);
    chk("R5 pulse", {31'd0, irq}, 32'd1);
    tick(1);
    chk("R5 pulse ends", {31'd0, irq}, 32'd0);
    tick(5);
    chk("R4 stays zero", rd_data, 32'd0);

    // R3 rewrite mid-run
    wr(1'b0, 32'd100);
    tick(10);
    chk("R3 running", rd_data, 32'd90);
    wr(1'b0, 32'd7);
    chk("R3 reloaded", rd_data, 32'd7);
    tick(6);
    chk("R3 no pulse yet", {31'd0, irq}, 32'd0);
    tick(1);
    chk("R3 pulse from new value", {31'd0, irq}, 32'd1);

    // R7 write on the expiry clock
    wr(1'b0, 32'd4);
    tick(3);
    chk("R7 count at one", rd_data, 32'd1);
    wr(1'b0, 32'd9);
    chk("R7 no pulse", {31'd0, irq}, 32'd0);
    chk("R7 new count", rd_data, 32'd9);

    // R6 periodic pattern
    wr(1'b0, 32'h8000_0005);
    pulses = 0;
    for (int k = 1; k <= 20; k++) begin
      tick(1);
      if (irq) pulses++;
      if ((k % 5 == 0) != irq) begin
        checks++;
        errors++;
        $display("FAIL R6 periodic at %0d: actual %0d expected %0d", k, irq, (k % 5 == 0));
      end
    end
    chk("R6 pulse count", pulses, 32'd4);
    wr(1'b0, 32'd0);
    chk("R4 stop after periodic", rd_data, 32'd0);

    // R8 watchdog build
    wr(1'b1, 32'h8000_0006);
    chk("R8 bit31 ignored", rd_data_wd, 32'd6);
    tick(5);
    chk("R8 no early request", {31'd0, rst_req_wd}, 32'd0);
    tick(1);
    chk("R8 request", {31'd0, rst_req_wd}, 32'd1);
    chk("R8 irq low", {31'd0, irq_wd}, 32'd0);
    tick(1);
    chk("R8 request ends", {31'd0, rst_req_wd}, 32'd0);
    tick(4);
    chk("R8 stays stopped", rd_data_wd, 32'd0);

    // R1 asynchronous reset mid-run
    wr(1'b0, 32'd50);
    tick(2);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", rd_data, 32'd0);
    tick(1);
    rst_n = 1'b1;
    tick(1);

    // R6 long period
    wr(1'b0, 32'h8001_3880);
    tick(79999);
    chk("R6 long no early", {31'd0, irq}, 32'd0);
    tick(1);
    chk("R6 long pulse", {31'd0, irq}, 32'd1);
    chk("R6 long reloaded", rd_data, 32'h8001_3880);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule